// File: doc/BRIEF.md
# LIN Transmit Stuck-Dominant Guard

This block sits on the controller side of a LIN node, between the protocol engine's transmit output and the transceiver's transmit pin. It does two jobs. First, it keeps the transmit pin recessive while the supply is in a critical low-voltage band. In that band, driving dominant in normal mode can leave the bus latched dominant. Second, it watches the receive line and reports a bus that stays dominant for longer than a set number of clock cycles.

A low-voltage interrupt input blocks transmission straight away. Transmission resumes only when the interrupt has gone away and the low-voltage flag also shows that the supply is back. When the receive line stays dominant past the limit, a sticky fault is raised. While the fault is set, the block holds the transmit pin recessive and asks the transceiver's mode controller to enter sleep. Software clears the fault with a one-cycle clear pulse. The clear takes effect only once the bus reads recessive again.

The receive line and both low-voltage inputs are asynchronous. Each passes through a two-flop synchronizer before the block uses it. The engine's transmit request is on the block clock and is gated without added delay.

Top module: `lin_tx_guard`

## Requirements
- R1: While `rst` is high, `txd_out` is 1 (recessive) whatever `tx_req` is. After a synchronous reset, `sleep_req`, `stuck_fault` and `lv_inhibit` are 0.
- R2: With no low-voltage block and no fault, `txd_out` equals `tx_req` in the same cycle (0 = dominant, 1 = recessive).
- R3: `lv_irq` = 1 forces `txd_out` to 1 starting from the second rising edge after the pin rises, and not earlier. `lv_inhibit` reads 1 from the third rising edge.
- R4: Once set, `lv_inhibit` stays set while either `lv_irq` or `lv_flag` is 1, where `lv_flag` = 1 means the supply is still low. It clears on the third rising edge after both pins are 0. `lv_flag` on its own never sets the inhibit.
- R5: `stuck_fault` sets if and only if `rxd` (0 = dominant) is held 0 across at least `STUCK_LIMIT` consecutive rising edges. It becomes visible after rising edge `STUCK_LIMIT`+2, counted from the first low edge.
- R6: `stuck_fault` is sticky. While it is 1, `sleep_req` is 1 and `txd_out` is 1 whatever `tx_req` is.
- R7: A one-cycle `fault_clr` pulse clears `stuck_fault` only if the synchronized `rxd` is 1. A pulse while the bus still reads dominant is ignored.
- R8: The dominant-time count restarts from zero whenever synchronized `rxd` reads 1. After a clear, a fresh fault needs another full `STUCK_LIMIT` low edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Transmit request from the protocol engine, 0 = dominant |
| rxd | input | 1 | Receive line from the transceiver (asynchronous), 0 = dominant |
| lv_irq | input | 1 | Low-voltage interrupt (asynchronous), 1 = critical band entered |
| lv_flag | input | 1 | Low-voltage flag (asynchronous), 1 = supply still low |
| fault_clr | input | 1 | Write-one-to-clear pulse for the stuck fault |
| txd_out | output | 1 | Gated transmit pin toward the transceiver |
| sleep_req | output | 1 | Request to the transceiver mode controller to enter sleep |
| lv_inhibit | output | 1 | Status: transmission held off by low voltage |
| stuck_fault | output | 1 | Status: sticky stuck-dominant fault |

## Verification
Each result has a fixed latency. The pass-through of `tx_req` is combinational, so it is checked in the same cycle. Forcing `txd_out` after `lv_irq` takes two rising edges, one for each synchronizer stage. The registered `lv_inhibit` status and its release both take three edges. The stuck fault appears after `STUCK_LIMIT`+2 edges. The bench drives its inputs and samples the outputs on falling edges. It counts exactly those edges before each check, and it also checks one edge early so that a wrong latency is seen. The bench sweeps the dominant duration from 1 to `STUCK_LIMIT`+3 edges, and for each duration it compares the fault against the arithmetic rule "at least `STUCK_LIMIT` edges".

// File: rtl/lin_guard_pkg.sv
package lin_guard_pkg;

    // Synchronized line bundle
    typedef struct packed {
        logic rxd;
        logic lv_irq;
        logic lv_flag;
    } line_t;

    localparam int LINE_W = $bits(line_t);

    // Idle values: bus recessive, supply good
    localparam line_t LINE_IDLE = '{rxd: 1'b1, lv_irq: 1'b0, lv_flag: 1'b0};

    typedef enum logic {
        LV_RUN  = 1'b0,
        LV_HOLD = 1'b1
    } lv_state_e;

    typedef enum logic {
        STK_OK    = 1'b0,
        STK_FAULT = 1'b1
    } stk_state_e;

    // Force recessive (1) whenever any blocking cause is active
    function automatic logic gate_txd(input logic req, input logic block);
        return req | block;
    endfunction

endpackage

// File: rtl/lin_guard_sync.sv
module lin_guard_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/lin_guard_lv.sv
module lin_guard_lv (
    input  logic clk,
    input  logic rst,
    input  logic irq_s,
    input  logic flag_s,
    output logic inhibit
);
    import lin_guard_pkg::*;

    lv_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            LV_RUN:  if (irq_s) state_d = LV_HOLD;
            LV_HOLD: if (!irq_s && !flag_s) state_d = LV_RUN;
            default: state_d = LV_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LV_RUN;
        else     state_q <= state_d;
    end

    assign inhibit = (state_q == LV_HOLD);

    // R4
    release_needs_recovery_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(inhibit) |-> $past(!irq_s && !flag_s));

    // R4
    flag_alone_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inhibit) |-> $past(irq_s));

endmodule

// File: rtl/lin_guard_stuck.sv
module lin_guard_stuck #(
    parameter int STUCK_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_s,
    input  logic clr,
    output logic fault
);
    import lin_guard_pkg::*;

    localparam int                CNT_W   = $clog2(STUCK_LIMIT) + 1;
    localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(STUCK_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    stk_state_e       state_q, state_d;
    logic             hit;

    // Dominant-time counter, restarts on recessive, saturates at the limit
    always_ff @(posedge clk) begin
        if (rst || rxd_s)        cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign hit = !rxd_s && (cnt_q == CNT_TOP);

    always_comb begin
        state_d = state_q;
        case (state_q)
            STK_OK:    if (hit) state_d = STK_FAULT;
            STK_FAULT: if (clr && rxd_s) state_d = STK_OK;
            default:   state_d = STK_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= STK_OK;
        else     state_q <= state_d;
    end

    assign fault = (state_q == STK_FAULT);

    // R5
    fault_needs_dominant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(!rxd_s));

    // R7
    clear_needs_recessive_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault) |-> $past(clr && rxd_s));

    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        rxd_s |=> (cnt_q == '0));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_TOP);

endmodule

// File: rtl/lin_tx_guard.sv
module lin_tx_guard #(
    parameter int SYNC_STAGES = 2,
    parameter int STUCK_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_req,
    input  logic rxd,
    input  logic lv_irq,
    input  logic lv_flag,
    input  logic fault_clr,
    output logic txd_out,
    output logic sleep_req,
    output logic lv_inhibit,
    output logic stuck_fault
);
    import lin_guard_pkg::*;

    line_t raw_lines, sync_lines;
    logic  inhibit_w, fault_w;

    assign raw_lines = '{rxd: rxd, lv_irq: lv_irq, lv_flag: lv_flag};

    lin_guard_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (sync_lines)
    );

    lin_guard_lv u_lv (
        .clk    (clk),
        .rst    (rst),
        .irq_s  (sync_lines.lv_irq),
        .flag_s (sync_lines.lv_flag),
        .inhibit(inhibit_w)
    );

    lin_guard_stuck #(
        .STUCK_LIMIT(STUCK_LIMIT)
    ) u_stuck (
        .clk  (clk),
        .rst  (rst),
        .rxd_s(sync_lines.rxd),
        .clr  (fault_clr),
        .fault(fault_w)
    );

    assign txd_out     = gate_txd(tx_req, rst | sync_lines.lv_irq | inhibit_w | fault_w);
    assign sleep_req   = fault_w;
    assign lv_inhibit  = inhibit_w;
    assign stuck_fault = fault_w;

    // R1
    reset_recessive_chk: assert property (@(posedge clk)
        rst |-> txd_out);

    // R3
    lv_blocks_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_lines.lv_irq || lv_inhibit) |-> txd_out);

    // R6
    fault_holds_tx_chk: assert property (@(posedge clk) disable iff (rst)
        stuck_fault |-> (txd_out && sleep_req));

    // R6
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stuck_fault && !fault_clr) |=> stuck_fault);

endmodule

// File: tb/sim_lin_tx_guard.sv
module sim_lin_tx_guard;

    localparam int LIMIT = 8;

    logic clk = 1'b0;
    logic rst, tx_req, rxd, lv_irq, lv_flag, fault_clr;
    logic txd_out, sleep_req, lv_inhibit, stuck_fault;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    lin_tx_guard #(.SYNC_STAGES(2), .STUCK_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst(rst), .tx_req(tx_req), .rxd(rxd),
        .lv_irq(lv_irq), .lv_flag(lv_flag), .fault_clr(fault_clr),
        .txd_out(txd_out), .sleep_req(sleep_req),
        .lv_inhibit(lv_inhibit), .stuck_fault(stuck_fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_req = 1'b0; rxd = 1'b1;
        lv_irq = 1'b0; lv_flag = 1'b0; fault_clr = 1'b0;
        tick(3);
        check("R1 txd in reset", txd_out, 1'b1);
        check("R1 sleep", sleep_req, 1'b0);
        check("R1 fault", stuck_fault, 1'b0);
        check("R1 inhibit", lv_inhibit, 1'b0);
        rst = 1'b0;
        tick(3);

        // R2 pass-through for both levels
        for (int v = 0; v < 2; v++) begin
            tx_req = v[0];
            #1 check("R2 pass-through", txd_out, v[0]);
            tick(1);
        end

        // R3 interrupt latency
        tx_req = 1'b0; lv_irq = 1'b1; lv_flag = 1'b1;
        tick(1); check("R3 not before 2nd edge", txd_out, 1'b0);
        tick(1); check("R3 txd forced", txd_out, 1'b1);
        check("R3 status not yet", lv_inhibit, 1'b0);
        tick(1); check("R3 status set", lv_inhibit, 1'b1);

        // R4 hold while flag still low-voltage
        lv_irq = 1'b0;
        tick(4);
        check("R4 held by flag", lv_inhibit, 1'b1);
        check("R4 txd held", txd_out, 1'b1);
        lv_flag = 1'b0;
        tick(2); check("R4 not released early", lv_inhibit, 1'b1);
        tick(1); check("R4 released", lv_inhibit, 1'b0);
        check("R4 tx resumes", txd_out, 1'b0);
        lv_flag = 1'b1;
        tick(4);
        check("R4 flag alone no inhibit", lv_inhibit, 1'b0);
        check("R4 flag alone txd", txd_out, 1'b0);
        lv_flag = 1'b0;
        tick(3);

        // R5 sweep of dominant duration
        for (int m = 1; m <= LIMIT + 3; m++) begin
            rxd = 1'b0; tick(m);
            rxd = 1'b1; tick(4);
            check("R5 fault vs duration", stuck_fault, (m >= LIMIT) ? 1'b1 : 1'b0);
            if (m >= LIMIT) begin
                tx_req = 1'b0;
                #1 check("R6 txd held", txd_out, 1'b1);
                check("R6 sleep", sleep_req, 1'b1);
                tick(5);
                check("R6 sticky", stuck_fault, 1'b1);
                fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
                check("R7 cleared", stuck_fault, 1'b0);
                check("R7 sleep dropped", sleep_req, 1'b0);
            end
        end

        // R5 exact visibility edge
        rxd = 1'b0;
        tick(LIMIT + 1); check("R5 not at edge L+1", stuck_fault, 1'b0);
        tick(1);         check("R5 at edge L+2", stuck_fault, 1'b1);

        // R7 clear ignored while dominant
        fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
        check("R7 clear ignored", stuck_fault, 1'b1);
        rxd = 1'b1; tick(1);
        fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
        check("R7 clear before sync high ignored", stuck_fault, 1'b1);
        tick(2);
        fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
        check("R7 clear accepted", stuck_fault, 1'b0);

        // R8 count restarts after recessive
        rxd = 1'b0; tick(LIMIT - 1);
        rxd = 1'b1; tick(2);
        rxd = 1'b0; tick(LIMIT - 1);
        rxd = 1'b1; tick(4);
        check("R8 restart no fault", stuck_fault, 1'b0);
        tx_req = 1'b1;
        #1 check("R2 recessive pass", txd_out, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule